// File: doc/BRIEF.md
# Pipelined Burst SRAM with Byte-Lane Writes

This block is a single-port synchronous static RAM of 18-bit words whose depth is set by an address-width parameter. Every synchronous input (address, write data, the two access strobes, the advance control, chip select and the two lane write enables) is captured on the rising clock edge. The captured access is then carried out, and read data passes through an output register, so a read sampled at one edge shows on the bus one edge later. Writes are self-timed from the clock and split into two 9-bit lanes.

A new access is opened by one of two strobes: a processor strobe that always reads, or a controller strobe that reads or writes depending on the lane write enables. While both strobes are high, an internal two-bit burst sequencer walks the remaining three words of the aligned group of four in interleaved order. An advance input steps the sequencer, or leaves it in place to insert a wait state. The data bus is modelled as an input word, an output word and a drive enable. The drive enable is gated by an asynchronous, active-low output enable.

Top module: `ssram_pipe`

## Requirements
- R1: A write updates only the enabled lanes: `wlo_n` low writes bits 8..0 and `whi_n` low writes bits 17..9. Either lane or both may be written in one cycle, and a disabled lane keeps its old contents.
- R2: A read sampled at clock edge N is driven on `dq_o` with `dq_oe` high from edge N+1 until edge N+2 (one cycle of output-register latency).
- R3: With `pstart_n` low and `sel_n` low, the sampled address is loaded and read, whatever `cstart_n`, `wlo_n` and `whi_n` are. A processor write therefore takes two cycles: the strobe with the address, then both strobes high with the write enables and the data.
- R4: With `cstart_n` low, `pstart_n` high and `sel_n` low, the sampled address is loaded. The cycle writes if either lane enable is low and reads otherwise.
- R5: `sel_n` is sampled only when a strobe is low. A strobe with `sel_n` high deselects the block: there is no access and no drive, and later cycles with both strobes high do nothing until a selected strobe.
- R6: With both strobes high after a selected load, `advance_n` low steps a two-bit count before the access, and `advance_n` high repeats the current word. The word address is the base with its low two bits XORed with the count, so the fourth step returns to the base. Each of these cycles reads or writes according to the lane enables.
- R7: `dq_oe` is high only when `oe_n` is low and the access of the previous cycle was a read. `oe_n` acts combinationally and is never registered.
- R8: While `wlo_n` or `whi_n` is low at the ports, `dq_oe` is low, so a write that follows a read never meets a driven bus.
- R9: A read of the word written in the immediately preceding cycle returns the new value.
- R10: After reset `dq_oe` is low, and no access takes place until a selected strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset of control state |
| addr | input | ADDR_W | Word address, used when a strobe is low |
| pstart_n | input | 1 | Processor access strobe, active low, always reads |
| cstart_n | input | 1 | Controller access strobe, active low, reads or writes |
| advance_n | input | 1 | Burst advance, active low; high inserts a wait state |
| sel_n | input | 1 | Chip select, active low, sampled with a strobe |
| wlo_n | input | 1 | Lower lane write enable (bits 8..0), active low |
| whi_n | input | 1 | Upper lane write enable (bits 17..9), active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| dq_i | input | 2*LANE_W | Write data, sampled with the access |
| dq_o | output | 2*LANE_W | Registered read data |
| dq_oe | output | 1 | Bus drive enable for `dq_o` |

## Verification
The assertions assume that the ports are stable around the rising edge and that reset is held for at least one edge. The bench changes every input on the falling edge and releases reset there. The assertions also assume that any bus value seen while a lane enable is low comes from the write data, not from the block. The bench therefore drives write data only in cycles that have a lane enable low, and it expects the drive enable to be low in exactly those cycles. The checks of deselect, of ignored write enables and of reset then read words back through normal selected accesses, never through internal state.

// File: rtl/ssram_burst_seq.sv
module ssram_burst_seq #(
  parameter int ADDR_W  = 6,
  parameter int BURST_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              sel,
  input  logic              step,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] acc_addr,
  output logic              acc_live
);
  logic [ADDR_W-1:0]  base;
  logic [BURST_W-1:0] cnt;
  logic [BURST_W-1:0] cnt_nxt;
  logic               live;

  assign cnt_nxt  = cnt + BURST_W'(step);
  assign acc_addr = load ? addr_in
                         : {base[ADDR_W-1:BURST_W], base[BURST_W-1:0] ^ cnt_nxt};
  assign acc_live = load ? sel : live;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base <= '0;
      cnt  <= '0;
      live <= 1'b0;
    end else if (load) begin
      base <= addr_in;
      cnt  <= '0;
      live <= sel;
    end else begin
      cnt <= cnt_nxt;
    end
  end
endmodule

// File: rtl/ssram_pipe.sv
module ssram_pipe #(
  parameter int ADDR_W  = 6,
  parameter int LANE_W  = 9,
  parameter int BURST_W = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   addr,
  input  logic                pstart_n,
  input  logic                cstart_n,
  input  logic                advance_n,
  input  logic                sel_n,
  input  logic                wlo_n,
  input  logic                whi_n,
  input  logic                oe_n,
  input  logic [2*LANE_W-1:0] dq_i,
  output logic [2*LANE_W-1:0] dq_o,
  output logic                dq_oe
);
  localparam int DW    = 2 * LANE_W;
  localparam int DEPTH = 1 << ADDR_W;

  logic [ADDR_W-1:0] r_addr;
  logic [DW-1:0]     r_din;
  logic              r_ps_n, r_cs_n, r_adv_n, r_sel_n, r_wlo_n, r_whi_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r_addr  <= '0;
      r_din   <= '0;
      r_ps_n  <= 1'b1;
      r_cs_n  <= 1'b1;
      r_adv_n <= 1'b1;
      r_sel_n <= 1'b1;
      r_wlo_n <= 1'b1;
      r_whi_n <= 1'b1;
    end else begin
      r_addr  <= addr;
      r_din   <= dq_i;
      r_ps_n  <= pstart_n;
      r_cs_n  <= cstart_n;
      r_adv_n <= advance_n;
      r_sel_n <= sel_n;
      r_wlo_n <= wlo_n;
      r_whi_n <= whi_n;
    end
  end

  logic              load;
  logic [ADDR_W-1:0] acc_addr;
  logic              acc_live;

  assign load = !r_ps_n || !r_cs_n;

  ssram_burst_seq #(.ADDR_W(ADDR_W), .BURST_W(BURST_W)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .sel      (!r_sel_n),
    .step     (!load && !r_adv_n),
    .addr_in  (r_addr),
    .acc_addr (acc_addr),
    .acc_live (acc_live)
  );

  logic wr_any, wr_lo, wr_hi, rd_now, rd_valid;

  assign wr_any = acc_live && r_ps_n && (!r_wlo_n || !r_whi_n);
  assign wr_lo  = wr_any && !r_wlo_n;
  assign wr_hi  = wr_any && !r_whi_n;
  assign rd_now = acc_live && !wr_any;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_lo) mem[acc_addr][LANE_W-1:0]  <= r_din[LANE_W-1:0];
    if (wr_hi) mem[acc_addr][DW-1:LANE_W] <= r_din[DW-1:LANE_W];
    if (rd_now) dq_o <= mem[acc_addr];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_valid <= 1'b0;
    else        rd_valid <= rd_now;
  end

  assign dq_oe = rd_valid && !oe_n && wlo_n && whi_n;
endmodule

// File: rtl/ssram_pipe_chk.sv
module ssram_pipe_chk (
  input logic clk,
  input logic rst_n,
  input logic pstart_n,
  input logic sel_n,
  input logic wlo_n,
  input logic whi_n,
  input logic oe_n,
  input logic dq_oe,
  input logic wr_any,
  input logic rd_valid
);
  logic [1:0] age;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         age <= '0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  p_oe_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> !dq_oe);

  p_no_fight_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!wlo_n || !whi_n) |-> !dq_oe);

  p_write_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_any |=> !rd_valid);

  p_ignore_we_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (age != 2'd0 && $past(!pstart_n)) |-> !wr_any);

  p_desel_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd3 && $past(!pstart_n && sel_n, 2)) |-> !dq_oe);
endmodule

bind ssram_pipe ssram_pipe_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .pstart_n (pstart_n),
  .sel_n    (sel_n),
  .wlo_n    (wlo_n),
  .whi_n    (whi_n),
  .oe_n     (oe_n),
  .dq_oe    (dq_oe),
  .wr_any   (wr_any),
  .rd_valid (rd_valid)
);

// File: tb/ssram_pipe_tb.sv
module ssram_pipe_tb;
  localparam int AW    = 6;
  localparam int DW    = 18;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rst_n;
  logic [AW-1:0] addr;
  logic [DW-1:0] dq_i;
  logic [DW-1:0] dq_o;
  logic          dq_oe;
  logic          ps, cs, adv, sel, wl, wh, oe;

  ssram_pipe #(.ADDR_W(AW), .LANE_W(9), .BURST_W(2)) u_dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .pstart_n(ps), .cstart_n(cs),
    .advance_n(adv), .sel_n(sel), .wlo_n(wl), .whi_n(wh), .oe_n(oe),
    .dq_i(dq_i), .dq_o(dq_o), .dq_oe(dq_oe)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [DW-1:0] ref_mem [DEPTH];
  logic [AW-1:0] m_base;
  logic [1:0]    m_cnt;
  bit            m_act;
  bit            pv;
  logic [DW-1:0] pd;

  function automatic logic [DW-1:0] pat(int a, int k);
    return DW'(a * 4099 + k * 2731 + 77);
  endfunction

  task automatic chk(bit ok, string tag, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: got %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic acc(bit ips, bit ics, bit iadv, bit isel, bit iwl, bit iwh,
                     logic [AW-1:0] a, logic [DW-1:0] d, string tag);
    bit ld, wr, rd;
    logic [AW-1:0] ea;
    logic [DW-1:0] nd;
    ld = !ips || !ics;
    if (ld) begin
      m_base = a; m_cnt = 2'd0; m_act = !isel; ea = a;
    end else begin
      if (!iadv) m_cnt = m_cnt + 2'd1;
      ea = {m_base[AW-1:2], m_base[1:0] ^ m_cnt};
    end
    wr = m_act && ips && (!iwl || !iwh);
    rd = m_act && !wr;
    if (wr) begin
      if (!iwl) ref_mem[ea][8:0]  = d[8:0];
      if (!iwh) ref_mem[ea][17:9] = d[17:9];
    end
    nd = ref_mem[ea];
    ps = ips; cs = ics; adv = iadv; sel = isel; wl = iwl; wh = iwh;
    addr = a; dq_i = d;
    @(posedge clk);
    @(negedge clk);
    if (!iwl || !iwh)
      chk(dq_oe == 1'b0, "R8", "drive during write", DW'(dq_oe), '0);
    else if (pv && !oe)
      chk(dq_oe == 1'b1 && dq_o == pd, tag, "read data", dq_oe ? dq_o : 'x, pd);
    else
      chk(dq_oe == 1'b0, tag, "bus idle", DW'(dq_oe), '0);
    pv = rd;
    pd = nd;
  endtask

  task automatic idle(string tag);
    acc(1, 0, 1, 1, 1, 1, '0, '0, tag);
  endtask

  task automatic rd_p(int a, string tag);
    acc(0, 1, 1, 0, 1, 1, AW'(a), '0, tag);
  endtask

  task automatic wr_c(int a, bit iwl, bit iwh, logic [DW-1:0] d, string tag);
    acc(1, 0, 1, 0, iwl, iwh, AW'(a), d, tag);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    ps = 1; cs = 1; adv = 1; sel = 1; wl = 1; wh = 1; oe = 0;
    addr = '0; dq_i = '0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk(dq_oe == 1'b0, "R10", "drive in reset", DW'(dq_oe), '0);
    rst_n = 1'b1;
    m_act = 0; m_cnt = 0; m_base = '0; pv = 0;
  endtask

  task automatic oe_probe(int a);
    rd_p(a, "R7");
    ps = 1; cs = 0; sel = 1; adv = 1; wl = 1; wh = 1;
    @(posedge clk);
    @(negedge clk);
    oe = 1'b1;
    #1;
    chk(dq_oe == 1'b0, "R7", "oe_n high async", DW'(dq_oe), '0);
    oe = 1'b0;
    #1;
    chk(dq_oe == 1'b1 && dq_o == pd, "R7", "oe_n low async", dq_oe ? dq_o : 'x, pd);
    m_act = 0;
    pv = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    do_reset();

    acc(1, 1, 0, 0, 0, 0, 6'd5, pat(5, 99), "R10");

    for (int a = 0; a < DEPTH; a++) wr_c(a, 0, 0, pat(a, 0), "R4");
    for (int a = 0; a < DEPTH; a++) acc(0, a[0], 1, 0, 1, 1, AW'(a), '0, "R2");
    idle("R2");
    for (int a = 0; a < 8; a++) wr_c(a * 7, 1, 1, pat(a, 50), "R4");
    idle("R4");

    for (int a = 0; a < 16; a++) wr_c(a, 0, 1, pat(a, 1), "R1");
    for (int a = 8; a < 24; a++) wr_c(a, 1, 0, pat(a, 2), "R1");
    for (int a = 0; a < 24; a++) rd_p(a, "R1");
    idle("R1");

    for (int a = 30; a < 34; a++) begin
      acc(0, 1, 1, 0, 0, 0, AW'(a), pat(a, 3), "R3");
      rd_p(a, "R3");
      acc(0, 0, 1, 0, 1, 1, AW'(a), '0, "R3");
      acc(1, 1, 1, 0, 0, 0, AW'(a + 9), pat(a, 4), "R3");
      rd_p(a, "R3");
      idle("R3");
    end

    wr_c(40, 0, 0, pat(40, 5), "R9");
    rd_p(40, "R9");
    wr_c(41, 1, 0, pat(41, 5), "R9");
    rd_p(41, "R9");
    idle("R9");

    for (int b = 0; b < 4; b++) begin
      rd_p(44 + b, "R6");
      for (int s = 0; s < 4; s++) acc(1, 1, 0, 0, 1, 1, AW'(s * 11), '0, "R6");
      acc(1, 1, 1, 0, 1, 1, '0, '0, "R6");
      acc(1, 1, 0, 0, 1, 1, '0, '0, "R6");
      idle("R6");
    end

    wr_c(50, 0, 0, pat(50, 6), "R6");
    acc(1, 1, 0, 0, 0, 0, 6'd3, pat(50, 7), "R6");
    acc(1, 1, 1, 0, 0, 1, 6'd9, pat(50, 8), "R6");
    acc(1, 1, 0, 0, 1, 0, 6'd0, pat(50, 9), "R6");
    acc(1, 1, 0, 0, 0, 0, 6'd0, pat(50, 10), "R6");
    acc(1, 1, 0, 0, 0, 0, 6'd0, pat(50, 11), "R6");
    rd_p(50, "R6");
    for (int s = 0; s < 4; s++) acc(1, 1, 0, 0, 1, 1, '0, '0, "R6");
    idle("R6");

    oe_probe(12);
    oe_probe(47);
    oe = 1'b1;
    rd_p(13, "R7");
    idle("R7");
    oe = 1'b0;
    idle("R7");

    rd_p(20, "R5");
    acc(1, 0, 1, 1, 1, 1, 6'd60, '0, "R5");
    acc(1, 1, 0, 0, 0, 0, 6'd0, pat(20, 12), "R5");
    acc(1, 1, 0, 0, 1, 1, 6'd0, '0, "R5");
    acc(1, 1, 1, 0, 1, 1, 6'd0, '0, "R5");
    acc(0, 1, 1, 1, 1, 1, 6'd20, '0, "R5");
    acc(1, 1, 0, 0, 1, 1, 6'd0, '0, "R5");
    for (int a = 20; a < 24; a++) rd_p(a, "R5");
    rd_p(60, "R5");
    idle("R5");

    do_reset();
    acc(1, 1, 0, 0, 0, 0, 6'd0, pat(0, 13), "R10");
    acc(1, 1, 1, 0, 1, 1, 6'd0, '0, "R10");
    rd_p(0, "R10");
    rd_p(1, "R10");
    idle("R10");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule